// File: doc/BRIEF.md
# Scanline Video Memory Fetch Scheduler

This block decides, dot by dot, which video memory read a tile-based 2D graphics engine issues along one scanline. A line counter walks the line in four phases. The background phase comes first: 33 tile slots of 8 dots each. A quiet window of 8 dots follows, then the sprite phase of 34 sliver slots of 2 dots each. The line ends on a single stretch dot that carries no request. That dot stands for the two half-dots the line gains around horizontal sync, which lengthen a 340-dot fetch budget to 341 dots.

Upstream logic supplies the attributes of the current tile. It reads the slot number from `tile_slot_o` and drives that tile's pattern base address and flip bit in the same cycle. It also drives a line-wide tile mode and an offset-row base. Before the sprite phase, a sprite sliver table is loaded through a write port. Each table entry holds a base address, a flip bit and a present bit. Each request leaves on a registered output with a valid strobe, an address and a tag `{phase, slot, plane}`.

The line-phase state machine has four states: `PH_TILE`, `PH_IDLE`, `PH_SPRITE` and `PH_STRETCH`. It has these transitions:
- `TILE_DONE`: `PH_TILE` to `PH_IDLE` after the last dot of tile slot 32.
- `IDLE_DONE`: `PH_IDLE` to `PH_SPRITE` after 8 dots.
- `SPRITE_DONE`: `PH_SPRITE` to `PH_STRETCH` after the last dot of sprite slot 33.
- `LINE_WRAP`: `PH_STRETCH` to `PH_TILE`.
- `HSYNC_RESTART`: any state to `PH_TILE`, with all counters cleared, whenever `hsync_start_i` is high at a clock edge.

Top module: `scanline_fetch_sched`

## Requirements
- R1: The line counter counts dots 0 to 340. Without a sync it wraps from 340 back to 0. When `hsync_start_i` is high at an edge, the next dot is 0, and the outputs show no request for that edge.
- R2: Dots 0 to 263 form the tile phase. The tile slot is dot/8 and the sub-dot is dot%8. Even sub-dots issue a request with plane index sub/2; odd sub-dots issue none. The tag is {phase[9:8], slot[7:2], plane[1:0]}, and the phase code is 0 for tile and 2 for sprite.
- R3: With `tile_mode_i` = 0 (plain), the four requests of a tile read base+0, base+1, base+2 and base+3 in that order, lowest address first. The tile flip bit has no effect in this mode.
- R4: With `tile_mode_i` = 1 (offset row), the first two requests read opt_base+2*slot and then opt_base+2*slot+1. The last two read base+0 and then base+1.
- R5: With `tile_mode_i` = 2 (wide tile), the left half (base, base+1) is fetched before the right half (base+8, base+9). A set tile flip bit puts the right half first, and each half is still fetched lower address first.
- R6: Dots 264 to 271 issue no request. Address and tag hold their last values through this window.
- R7: Dots 272 to 339 form the sprite phase. Sprite slot s is (dot-272)/2. Its plane 0 request is followed on the next dot by its plane 1 request, at the address one higher.
- R8: A sprite sliver reads base + 16*col + plane, where col = (s mod 2) XOR flip. A flipped sprite that fills an even/odd slot pair therefore fetches its two slivers in reverse order.
- R9: A sprite slot whose present bit is clear issues no request on either of its two dots, and the slots after it keep their dot positions.
- R10: Dot 340 is the stretch dot and issues no request.
- R11: Outputs are registered. The request for dot d appears after the clock edge at which the counter reads d. Reset clears valid, address and tag to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hsync_start_i | input | 1 | Restarts the line at dot 0 |
| tile_slot_o | output | 6 | Current tile slot, for the attribute lookup upstream |
| tile_base_i | input | 16 | Pattern base address of the current tile |
| tile_flip_i | input | 1 | Horizontal flip bit of the current tile |
| tile_mode_i | input | 2 | 0 plain, 1 offset row, 2 wide tile, 3 treated as plain |
| opt_base_i | input | 16 | Base address of the offset row |
| spr_we_i | input | 1 | Sprite table write strobe |
| spr_wslot_i | input | 6 | Sprite slot written (34 or above is ignored) |
| spr_wbase_i | input | 16 | Sprite sliver base address |
| spr_wflip_i | input | 1 | Sprite horizontal flip bit |
| spr_wpres_i | input | 1 | Sprite slot holds an entry |
| req_valid_o | output | 1 | A read request is present |
| req_addr_o | output | 16 | Read address |
| req_tag_o | output | 10 | {phase, slot, plane} |

## Verification
The bench sweeps whole lines, all 341 dots of each, in every tile mode. It uses random tile and sprite flips, sprite slots that are sometimes empty, and a final line with no sprites at all. It compares every dot against an arithmetic model.

The phase boundaries get the closest attention. A design that is off by one at dot 263, 271 or 339 would issue a request inside the quiet window or lose the last sprite plane. A design that forgot the stretch dot would wrap after 340 dots and drift one dot every line.

Flip handling is exercised in every mode. A design that reversed the planes instead of the halves would show up in wide mode. One that applied flip in plain mode would show up there. One that ignored the sprite flip would fetch the wrong column.

The bench also checks that address and tag stay unchanged through the quiet window. It checks that no request leaves on the edge where sync restarts the line.

// File: rtl/scanline_fetch_pkg.sv
package scanline_fetch_pkg;

    typedef enum logic [1:0] {
        PH_TILE    = 2'd0,
        PH_IDLE    = 2'd1,
        PH_SPRITE  = 2'd2,
        PH_STRETCH = 2'd3
    } fetch_phase_e;

    typedef enum logic [1:0] {
        TM_PLAIN  = 2'd0,
        TM_OFFSET = 2'd1,
        TM_WIDE   = 2'd2,
        TM_RSVD   = 2'd3
    } tile_mode_e;

endpackage

// File: rtl/line_phase_timer.sv
module line_phase_timer
    import scanline_fetch_pkg::*;
#(
    parameter int TILE_SLOTS = 33,
    parameter int TILE_DOTS  = 8,
    parameter int IDLE_DOTS  = 8,
    parameter int SPR_SLOTS  = 34,
    parameter int SPR_DOTS   = 2,
    parameter int SLW        = 6,
    parameter int SUBW       = 3,
    parameter int DW         = 9
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            hsync_start_i,
    output fetch_phase_e    phase_o,
    output logic [SLW-1:0]  slot_o,
    output logic [SUBW-1:0] sub_o,
    output logic [DW-1:0]   dot_o
);

    localparam int LINE_DOTS = TILE_SLOTS * TILE_DOTS + IDLE_DOTS + SPR_SLOTS * SPR_DOTS + 1;
    localparam logic [SUBW-1:0] TILE_SUB_LAST = SUBW'(TILE_DOTS - 1);
    localparam logic [SUBW-1:0] IDLE_SUB_LAST = SUBW'(IDLE_DOTS - 1);
    localparam logic [SUBW-1:0] SPR_SUB_LAST  = SUBW'(SPR_DOTS - 1);
    localparam logic [SLW-1:0]  TILE_SLOT_LAST = SLW'(TILE_SLOTS - 1);
    localparam logic [SLW-1:0]  SPR_SLOT_LAST  = SLW'(SPR_SLOTS - 1);
    localparam logic [DW-1:0]   DOT_LAST       = DW'(LINE_DOTS - 1);

    fetch_phase_e    state_q, state_d;
    logic [SLW-1:0]  slot_q, slot_d;
    logic [SUBW-1:0] sub_q, sub_d;
    logic [DW-1:0]   dot_q, dot_d;

    // Next-state logic: phase transitions are named TILE_DONE, IDLE_DONE,
    // SPRITE_DONE, LINE_WRAP and HSYNC_RESTART.
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        sub_d   = sub_q + 1'b1;
        unique case (state_q)
            PH_TILE: begin
                if (sub_q == TILE_SUB_LAST) begin
                    sub_d = '0;
                    if (slot_q == TILE_SLOT_LAST) begin
                        state_d = PH_IDLE;       // TILE_DONE
                        slot_d  = '0;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
            end
            PH_IDLE: begin
                if (sub_q == IDLE_SUB_LAST) begin
                    sub_d   = '0;
                    state_d = PH_SPRITE;         // IDLE_DONE
                end
            end
            PH_SPRITE: begin
                if (sub_q == SPR_SUB_LAST) begin
                    sub_d = '0;
                    if (slot_q == SPR_SLOT_LAST) begin
                        state_d = PH_STRETCH;    // SPRITE_DONE
                        slot_d  = '0;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
            end
            PH_STRETCH: begin
                state_d = PH_TILE;               // LINE_WRAP
                slot_d  = '0;
                sub_d   = '0;
            end
            default: begin
                state_d = PH_TILE;
                slot_d  = '0;
                sub_d   = '0;
            end
        endcase
        if (hsync_start_i) begin                 // HSYNC_RESTART
            state_d = PH_TILE;
            slot_d  = '0;
            sub_d   = '0;
        end
        if (hsync_start_i || dot_q == DOT_LAST) begin
            dot_d = '0;
        end else begin
            dot_d = dot_q + 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PH_TILE;
            slot_q  <= '0;
            sub_q   <= '0;
            dot_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            sub_q   <= sub_d;
            dot_q   <= dot_d;
        end
    end

    assign phase_o = state_q;
    assign slot_o  = slot_q;
    assign sub_o   = sub_q;
    assign dot_o   = dot_q;

endmodule

// File: rtl/tile_req_gen.sv
module tile_req_gen
    import scanline_fetch_pkg::*;
#(
    parameter int AW       = 16,
    parameter int SLW      = 6,
    parameter int SUBW     = 3,
    parameter int PLANES   = 4,
    parameter int HALF_OFS = 8
) (
    input  logic [SUBW-1:0] sub_i,
    input  logic [SLW-1:0]  slot_i,
    input  logic [AW-1:0]   base_i,
    input  logic            flip_i,
    input  logic [1:0]      mode_i,
    input  logic [AW-1:0]   opt_base_i,
    output logic            req_o,
    output logic [AW-1:0]   addr_o,
    output logic [1:0]      plane_o
);

    logic [SUBW-1:0] pidx;
    logic [1:0]      k;
    logic            half;
    logic [AW-1:0]   opt_row;
    tile_mode_e      mode;

    assign pidx    = sub_i >> 1;
    assign k       = pidx[1:0];
    assign req_o   = !sub_i[0] && (pidx < SUBW'(PLANES));
    assign plane_o = k;
    assign half    = k[1] ^ flip_i;
    assign opt_row = opt_base_i + {{(AW-SLW-1){1'b0}}, slot_i, 1'b0};
    assign mode    = tile_mode_e'(mode_i);

    always_comb begin
        unique case (mode)
            TM_OFFSET: addr_o = k[1] ? (base_i + AW'(k[0])) : (opt_row + AW'(k[0]));
            TM_WIDE:   addr_o = base_i + (half ? AW'(HALF_OFS) : '0) + AW'(k[0]);
            default:   addr_o = base_i + AW'(k);
        endcase
    end

endmodule

// File: rtl/sprite_slot_table.sv
module sprite_slot_table #(
    parameter int AW         = 16,
    parameter int SLW        = 6,
    parameter int SPR_SLOTS  = 34,
    parameter int COL_STRIDE = 16
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           we_i,
    input  logic [SLW-1:0] wslot_i,
    input  logic [AW-1:0]  wbase_i,
    input  logic           wflip_i,
    input  logic           wpres_i,
    input  logic [SLW-1:0] rd_slot_i,
    input  logic           rd_plane_i,
    output logic           req_o,
    output logic [AW-1:0]  addr_o
);

    logic [AW-1:0]      base_q [SPR_SLOTS];
    logic [SPR_SLOTS-1:0] flip_q;
    logic [SPR_SLOTS-1:0] pres_q;

    for (genvar i = 0; i < SPR_SLOTS; i++) begin : g_entry
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                pres_q[i] <= 1'b0;
            end else if (we_i && wslot_i == SLW'(i)) begin
                pres_q[i] <= wpres_i;
            end
        end
        always_ff @(posedge clk_i) begin
            if (we_i && wslot_i == SLW'(i)) begin
                base_q[i] <= wbase_i;
                flip_q[i] <= wflip_i;
            end
        end
    end

    logic          in_range;
    logic          col;
    logic [AW-1:0] rd_base;
    logic          rd_flip;
    logic          rd_pres;

    assign in_range = rd_slot_i < SLW'(SPR_SLOTS);

    always_comb begin
        rd_base = '0;
        rd_flip = 1'b0;
        rd_pres = 1'b0;
        if (in_range) begin
            rd_base = base_q[rd_slot_i];
            rd_flip = flip_q[rd_slot_i];
            rd_pres = pres_q[rd_slot_i];
        end
    end

    assign col    = rd_slot_i[0] ^ rd_flip;
    assign req_o  = rd_pres;
    assign addr_o = rd_base + (col ? AW'(COL_STRIDE) : '0) + AW'(rd_plane_i);

endmodule

// File: rtl/scanline_fetch_sched.sv
module scanline_fetch_sched
    import scanline_fetch_pkg::*;
#(
    parameter int AW         = 16,
    parameter int TILE_SLOTS = 33,
    parameter int TILE_DOTS  = 8,
    parameter int IDLE_DOTS  = 8,
    parameter int SPR_SLOTS  = 34,
    parameter int SPR_DOTS   = 2,
    parameter int HALF_OFS   = 8,
    parameter int COL_STRIDE = 16,
    parameter int SLW        = 6,
    parameter int TW         = SLW + 4
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           hsync_start_i,
    output logic [SLW-1:0] tile_slot_o,
    input  logic [AW-1:0]  tile_base_i,
    input  logic           tile_flip_i,
    input  logic [1:0]     tile_mode_i,
    input  logic [AW-1:0]  opt_base_i,
    input  logic           spr_we_i,
    input  logic [SLW-1:0] spr_wslot_i,
    input  logic [AW-1:0]  spr_wbase_i,
    input  logic           spr_wflip_i,
    input  logic           spr_wpres_i,
    output logic           req_valid_o,
    output logic [AW-1:0]  req_addr_o,
    output logic [TW-1:0]  req_tag_o
);

    localparam int SUB_MAX   = (TILE_DOTS > IDLE_DOTS) ?
                               ((TILE_DOTS > SPR_DOTS) ? TILE_DOTS : SPR_DOTS) :
                               ((IDLE_DOTS > SPR_DOTS) ? IDLE_DOTS : SPR_DOTS);
    localparam int SUBW      = (SUB_MAX > 8) ? $clog2(SUB_MAX) : 3;
    localparam int LINE_DOTS = TILE_SLOTS * TILE_DOTS + IDLE_DOTS + SPR_SLOTS * SPR_DOTS + 1;
    localparam int DW        = $clog2(LINE_DOTS);

    fetch_phase_e    phase_w;
    logic [SLW-1:0]  slot_w;
    logic [SUBW-1:0] sub_w;
    logic [DW-1:0]   dot_w;

    logic            t_req;
    logic [AW-1:0]   t_addr;
    logic [1:0]      t_plane;
    logic            s_req;
    logic [AW-1:0]   s_addr;

    line_phase_timer #(
        .TILE_SLOTS (TILE_SLOTS),
        .TILE_DOTS  (TILE_DOTS),
        .IDLE_DOTS  (IDLE_DOTS),
        .SPR_SLOTS  (SPR_SLOTS),
        .SPR_DOTS   (SPR_DOTS),
        .SLW        (SLW),
        .SUBW       (SUBW),
        .DW         (DW)
    ) u_timer (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .hsync_start_i (hsync_start_i),
        .phase_o       (phase_w),
        .slot_o        (slot_w),
        .sub_o         (sub_w),
        .dot_o         (dot_w)
    );

    tile_req_gen #(
        .AW       (AW),
        .SLW      (SLW),
        .SUBW     (SUBW),
        .PLANES   (4),
        .HALF_OFS (HALF_OFS)
    ) u_tile (
        .sub_i      (sub_w),
        .slot_i     (slot_w),
        .base_i     (tile_base_i),
        .flip_i     (tile_flip_i),
        .mode_i     (tile_mode_i),
        .opt_base_i (opt_base_i),
        .req_o      (t_req),
        .addr_o     (t_addr),
        .plane_o    (t_plane)
    );

    sprite_slot_table #(
        .AW         (AW),
        .SLW        (SLW),
        .SPR_SLOTS  (SPR_SLOTS),
        .COL_STRIDE (COL_STRIDE)
    ) u_sprites (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .we_i       (spr_we_i),
        .wslot_i    (spr_wslot_i),
        .wbase_i    (spr_wbase_i),
        .wflip_i    (spr_wflip_i),
        .wpres_i    (spr_wpres_i),
        .rd_slot_i  (slot_w),
        .rd_plane_i (sub_w[0]),
        .req_o      (s_req),
        .addr_o     (s_addr)
    );

    assign tile_slot_o = slot_w;

    // Output process: one registered request per dot
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_valid_o <= 1'b0;
            req_addr_o  <= '0;
            req_tag_o   <= '0;
        end else if (hsync_start_i) begin
            req_valid_o <= 1'b0;
        end else begin
            unique case (phase_w)
                PH_TILE: begin
                    req_valid_o <= t_req;
                    if (t_req) begin
                        req_addr_o <= t_addr;
                        req_tag_o  <= {PH_TILE, slot_w, t_plane};
                    end
                end
                PH_SPRITE: begin
                    req_valid_o <= s_req;
                    if (s_req) begin
                        req_addr_o <= s_addr;
                        req_tag_o  <= {PH_SPRITE, slot_w, 1'b0, sub_w[0]};
                    end
                end
                default: req_valid_o <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/scanline_fetch_chk.sv
module scanline_fetch_chk #(
    parameter int AW  = 16,
    parameter int TW  = 10,
    parameter int DW  = 9,
    parameter int DOT_LAST = 340
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          hsync_start_i,
    input logic          req_valid_o,
    input logic [AW-1:0] req_addr_o,
    input logic [TW-1:0] req_tag_o,
    input logic [1:0]    phase_w,
    input logic [DW-1:0] dot_w
);

    a_r1_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (dot_w == DW'(DOT_LAST) && !hsync_start_i) |=> dot_w == '0);

    a_r1_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        hsync_start_i |=> (dot_w == '0 && !req_valid_o));

    a_r2_odd_gap: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_o && req_tag_o[TW-1:TW-2] == 2'd0 && !hsync_start_i) |=> !req_valid_o);

    a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_w == 2'd1 && !hsync_start_i) |=> !req_valid_o);

    a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_o |-> ($stable(req_addr_o) && $stable(req_tag_o)));

    a_r7_plane_pair: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_o && req_tag_o[TW-1:TW-2] == 2'd2 && req_tag_o[1:0] == 2'd0 && !hsync_start_i)
        |=> (req_valid_o && req_tag_o[1:0] == 2'd1 && req_addr_o == $past(req_addr_o) + AW'(1)
             && req_tag_o[TW-3:2] == $past(req_tag_o[TW-3:2])));

    a_r10_stretch_at_end: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_w == 2'd3) |-> dot_w == DW'(DOT_LAST));

    always_comb begin
        if (!rst_i && req_valid_o) begin
            a_r2_phase_code: assert (req_tag_o[TW-1:TW-2] == 2'd0 || req_tag_o[TW-1:TW-2] == 2'd2);
        end
    end

endmodule

bind scanline_fetch_sched scanline_fetch_chk #(
    .AW       (AW),
    .TW       (TW),
    .DW       (DW),
    .DOT_LAST (LINE_DOTS - 1)
) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .hsync_start_i (hsync_start_i),
    .req_valid_o   (req_valid_o),
    .req_addr_o    (req_addr_o),
    .req_tag_o     (req_tag_o),
    .phase_w       (phase_w),
    .dot_w         (dot_w)
);

// File: tb/scanline_fetch_sched_bench.sv
module scanline_fetch_sched_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        hsync;
    logic [5:0]  tile_slot;
    logic [15:0] tile_base;
    logic        tile_flip;
    logic [1:0]  tile_mode;
    logic [15:0] opt_base;
    logic        spr_we;
    logic [5:0]  spr_wslot;
    logic [15:0] spr_wbase;
    logic        spr_wflip;
    logic        spr_wpres;
    logic        req_valid;
    logic [15:0] req_addr;
    logic [9:0]  req_tag;

    logic        tflip [64];
    logic        sflip [34];
    logic        spres [34];

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [15:0] held_addr = '0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanline_fetch_sched u_scanline_fetch_sched (
        .clk_i         (clk),
        .rst_i         (rst),
        .hsync_start_i (hsync),
        .tile_slot_o   (tile_slot),
        .tile_base_i   (tile_base),
        .tile_flip_i   (tile_flip),
        .tile_mode_i   (tile_mode),
        .opt_base_i    (opt_base),
        .spr_we_i      (spr_we),
        .spr_wslot_i   (spr_wslot),
        .spr_wbase_i   (spr_wbase),
        .spr_wflip_i   (spr_wflip),
        .spr_wpres_i   (spr_wpres),
        .req_valid_o   (req_valid),
        .req_addr_o    (req_addr),
        .req_tag_o     (req_tag)
    );

    // Upstream attribute lookup model
    always_comb begin
        tile_base = 16'h2000 + {5'd0, tile_slot, 5'd0};
        tile_flip = tflip[tile_slot];
    end

    function automatic logic [15:0] spr_base(int s);
        return 16'h6000 + 16'((s / 2) * 64);
    endfunction

    task automatic expect_dot(input int d, input int mode, output bit v,
                              output logic [15:0] a, output logic [9:0] tg, output string rq);
        v = 0; a = '0; tg = '0; rq = "R6";
        if (d < 264) begin
            int slot = d / 8;
            int sub  = d % 8;
            int k    = sub / 2;
            logic [15:0] b = 16'h2000 + 16'(slot * 32);
            rq = "R2";
            if (sub % 2 == 0) begin
                v  = 1;
                tg = {2'd0, 6'(slot), 2'(k)};
                if (mode == 1) begin
                    rq = "R4";
                    a  = (k < 2) ? 16'h0400 + 16'(2 * slot + k) : b + 16'(k - 2);
                end else if (mode == 2) begin
                    int half = (k / 2) ^ int'(tflip[slot]);
                    rq = "R5";
                    a  = b + 16'(half * 8 + k % 2);
                end else begin
                    rq = "R3";
                    a  = b + 16'(k);
                end
            end
        end else if (d < 272) begin
            rq = "R6";
        end else if (d < 340) begin
            int s = (d - 272) / 2;
            int p = (d - 272) % 2;
            int col = (s % 2) ^ int'(sflip[s]);
            rq = spres[s] ? (sflip[s] ? "R8" : "R7") : "R9";
            v  = spres[s];
            a  = spr_base(s) + 16'(col * 16 + p);
            tg = {2'd2, 6'(s), 2'(p)};
        end else begin
            rq = "R10";
        end
    endtask

    task automatic check_dot(input int d, input int mode);
        bit v; logic [15:0] a; logic [9:0] tg; string rq;
        expect_dot(d, mode, v, a, tg, rq);
        n_checks++;
        if (v) begin
            if (!(req_valid === 1'b1 && req_addr === a && req_tag === tg)) begin
                n_fail++;
                $display("FAIL %s dot %0d: got v=%0b a=%h t=%h, want v=1 a=%h t=%h",
                         rq, d, req_valid, req_addr, req_tag, a, tg);
            end
            held_addr = a;
        end else if (!(req_valid === 1'b0 && req_addr === held_addr)) begin
            n_fail++;
            $display("FAIL %s dot %0d: got v=%0b a=%h, want v=0 a=%h",
                     rq, d, req_valid, req_addr, held_addr);
        end
    endtask

    task automatic load_sprites(input int style);
        for (int s = 0; s < 34; s++) begin
            case (style)
                0: begin spres[s] = ($urandom % 4) != 0; sflip[s] = (($urandom % 2) == 1); end
                1: begin spres[s] = 1'b1; sflip[s] = ((s / 2) % 2) == 1; end
                default: begin spres[s] = 1'b0; sflip[s] = 1'b0; end
            endcase
            if (s % 2 == 1) sflip[s] = sflip[s - 1];
            @(negedge clk);
            spr_we    = 1'b1;
            spr_wslot = 6'(s);
            spr_wbase = spr_base(s);
            spr_wflip = sflip[s];
            spr_wpres = spres[s];
        end
        @(negedge clk);
        spr_we = 1'b0;
    endtask

    task automatic run_line(input int mode, input int tstyle, input int sstyle);
        for (int i = 0; i < 64; i++) begin
            tflip[i] = (tstyle == 0) ? (($urandom % 2) == 1) : 1'b1;
        end
        tile_mode = 2'(mode);
        load_sprites(sstyle);
        hsync = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
        // R1: the restart edge carries no request
        n_checks++;
        if (req_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 restart: got v=%0b, want v=0", req_valid);
        end
        for (int d = 0; d < 341; d++) begin
            @(negedge clk);
            check_dot(d, mode);
        end
        // R1: wrap to dot 0 after 341 dots with no sync
        @(negedge clk);
        check_dot(0, mode);
    endtask

    initial begin
        rst = 1'b1; hsync = 1'b0; tile_mode = 2'd0; opt_base = 16'h0400;
        spr_we = 1'b0; spr_wslot = '0; spr_wbase = '0; spr_wflip = 1'b0; spr_wpres = 1'b0;
        for (int i = 0; i < 64; i++) tflip[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        n_checks++;
        if (req_valid !== 1'b0 || req_addr !== 16'h0 || req_tag !== 10'h0) begin
            n_fail++;
            $display("FAIL R11 reset: got v=%0b a=%h t=%h, want 0 0 0", req_valid, req_addr, req_tag);
        end
        rst = 1'b0;
        run_line(0, 0, 0);   // R3 plain, random flips ignored
        run_line(1, 0, 0);   // R4 offset row
        run_line(2, 0, 0);   // R5 wide, random flips
        run_line(2, 1, 1);   // R5, R8 all flipped, all sprites present
        run_line(0, 0, 2);   // R9 no sprites
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule